// File: doc/BRIEF.md
# Pulse Hit Feature Extractor

This block watches one channel of digitized waveform samples, one 12-bit sample per clock. The first and last samples of each waveform are marked. It triggers on slope rather than amplitude: a hit opens when the rise from one sample to the next exceeds a programmable threshold. It then reports up to two hits per waveform. Each hit carries an integrated charge above a baseline and the index of the sample where it fired.

The baseline comes from a fixed block of 16 samples at the start of every waveform. Those samples are followed by a 4-sample guard gap, so the earliest sample that can fire is index 20. Charge is summed over a programmable number of samples, from 1 to 63, and saturates at the limits of the charge field. After the last sample, the block hands a result record to the consumer through a valid/ready handshake. A waveform that produced no hit yields no record; instead a one-cycle suppress pulse marks it so that it can be dropped.

Top module: `pulse_hit_extractor`

## Requirements
- R1: A sample with index 20 or above is a hit candidate when its value minus the previous sample's value, taken as a signed number, is strictly greater than `slope_thr`. A difference equal to the threshold does not fire.
- R2: The baseline is the sum of samples 0 to 15 of the current waveform, shifted right by 4 (rounded down).
- R3: The charge of a hit is the sum of (sample − baseline) over `int_len` samples starting at the hit sample. It is a signed two's complement value. If the last sample arrives first, the partial sum is reported. An `int_len` of 0 behaves as 1.
- R4: The charge saturates at +(2^(QW−1)−1) and −2^(QW−1) instead of wrapping.
- R5: The time of a hit is the index of the hit sample, where the sample flagged `smp_first` has index 0.
- R6: A second hit can fire only after the first window has closed and a later sample has shown a difference not above the threshold. At most two hits are recorded, and later candidates are ignored. `rec_hits` gives the count. The first hit is in slot 0 and the second in slot 1.
- R7: A waveform with no hit raises `supp_flag` for exactly one cycle, in the cycle after its last sample is taken. It produces no record.
- R8: A waveform with hits sets `rec_valid` in the cycle after its last sample. The record fields stay stable until `rec_ready` is seen high. An unused slot reads zero.
- R9: Samples of the next waveform are processed while a record is pending. If that waveform ends before the pending record is taken, its result replaces the pending one.
- R10: A synchronous active-high `rst` clears the sample history, the accumulators, the hit count, `rec_valid` and `supp_flag`.
- R11: Slopes at sample indices 0 to 19 never start a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | SW | Unsigned sample value |
| smp_first | input | 1 | Sample is index 0 of a waveform |
| smp_last | input | 1 | Sample is the final one of a waveform |
| slope_thr | input | SW | Slope threshold |
| int_len | input | LW | Integration window length in samples |
| rec_ready | input | 1 | Consumer takes the record |
| rec_valid | output | 1 | Record available |
| rec_hits | output | 2 | Number of hits in the record (1 or 2) |
| rec_q0 | output | QW | Charge of the first hit, signed |
| rec_t0 | output | TW | Time of the first hit |
| rec_q1 | output | QW | Charge of the second hit, signed |
| rec_t1 | output | TW | Time of the second hit |
| supp_flag | output | 1 | One-cycle pulse for a hitless waveform |

## Verification
The bench builds the block with a 14-bit charge field and otherwise default parameters. This puts both saturation limits within reach of a single 63-sample window of full-scale or near-zero samples under a high baseline. The narrower field also lets the reference model's clamp be compared against the design on every clock. The default 10-bit time field and the 16-plus-4 baseline layout are kept, so the guard region and the re-arm rule are exercised at their real positions.

// File: rtl/pulse_hit_extractor.sv
module pulse_hit_extractor #(
  parameter int SW      = 12,
  parameter int QW      = 20,
  parameter int TW      = 10,
  parameter int LW      = 6,
  parameter int PED_LEN = 16,
  parameter int PED_GAP = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic [SW-1:0]        smp_data,
  input  logic                 smp_first,
  input  logic                 smp_last,
  input  logic [SW-1:0]        slope_thr,
  input  logic [LW-1:0]        int_len,
  input  logic                 rec_ready,
  output logic                 rec_valid,
  output logic [1:0]           rec_hits,
  output logic signed [QW-1:0] rec_q0,
  output logic [TW-1:0]        rec_t0,
  output logic signed [QW-1:0] rec_q1,
  output logic [TW-1:0]        rec_t1,
  output logic                 supp_flag
);
  localparam int PLOG = $clog2(PED_LEN);
  localparam int PW   = SW + PLOG;
  localparam int HMIN = PED_LEN + PED_GAP;
  localparam logic signed [QW-1:0] QMAX = {1'b0, {(QW-1){1'b1}}};
  localparam logic signed [QW-1:0] QMIN = {1'b1, {(QW-1){1'b0}}};

  typedef enum logic [1:0] {S_ARM, S_INT, S_WAIT} st_t;

  logic [SW-1:0]        prev;
  logic [TW-1:0]        idx;
  logic [PW-1:0]        pacc;
  st_t                  st, st_n;
  logic [LW-1:0]        cnt, cnt_n;
  logic [1:0]           nh, nh_n;
  logic signed [QW-1:0] q [2];
  logic signed [QW-1:0] q_n [2];
  logic [TW-1:0]        t [2];
  logic [TW-1:0]        t_n [2];

  logic [TW-1:0]        cur;
  logic [SW-1:0]        ped;
  logic signed [SW:0]   diff, term;
  logic                 above, hit, end_smp;

  assign cur     = smp_first ? '0 : idx;
  assign ped     = pacc[PW-1:PLOG];
  assign diff    = $signed({1'b0, smp_data}) - $signed({1'b0, prev});
  assign term    = $signed({1'b0, smp_data}) - $signed({1'b0, ped});
  assign above   = diff > $signed({1'b0, slope_thr});
  assign hit     = (st == S_ARM) && (cur >= TW'(HMIN)) && above && (nh != 2'd2);
  assign end_smp = smp_valid && smp_last;

  function automatic logic signed [QW-1:0] sat_add(input logic signed [QW-1:0] a,
                                                   input logic signed [SW:0] b);
    logic [QW:0] s;
    s = {a[QW-1], a} + {{(QW-SW){b[SW]}}, b};
    if (s[QW] != s[QW-1]) return s[QW] ? QMIN : QMAX;
    return s[QW-1:0];
  endfunction

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    nh_n  = nh;
    q_n   = q;
    t_n   = t;
    if (smp_valid) begin
      case (st)
        S_ARM: if (hit) begin
          q_n[nh[0]] = {{(QW-SW-1){term[SW]}}, term};
          t_n[nh[0]] = cur;
          nh_n       = nh + 2'd1;
          cnt_n      = int_len - LW'(1);
          st_n       = (int_len <= LW'(1)) ? S_WAIT : S_INT;
        end
        S_INT: begin
          q_n[nh[1]] = sat_add(q[nh[1]], term);
          cnt_n      = cnt - LW'(1);
          if (cnt == LW'(1)) st_n = S_WAIT;
        end
        S_WAIT: if (!above) st_n = S_ARM;
        default: st_n = S_ARM;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev      <= '0;
      idx       <= '0;
      pacc      <= '0;
      st        <= S_ARM;
      cnt       <= '0;
      nh        <= '0;
      for (int i = 0; i < 2; i++) begin
        q[i] <= '0;
        t[i] <= '0;
      end
      rec_valid <= 1'b0;
      rec_hits  <= '0;
      rec_q0    <= '0;
      rec_t0    <= '0;
      rec_q1    <= '0;
      rec_t1    <= '0;
      supp_flag <= 1'b0;
    end else begin
      supp_flag <= end_smp && (nh_n == 2'd0);
      if (end_smp && (nh_n != 2'd0)) begin
        rec_valid <= 1'b1;
        rec_hits  <= nh_n;
        rec_q0    <= q_n[0];
        rec_t0    <= t_n[0];
        rec_q1    <= q_n[1];
        rec_t1    <= t_n[1];
      end else if (rec_ready) begin
        rec_valid <= 1'b0;
      end
      if (smp_valid) begin
        prev <= smp_data;
        idx  <= cur + 1'b1;
        if (cur == '0)                pacc <= PW'(smp_data);
        else if (cur < TW'(PED_LEN))  pacc <= pacc + PW'(smp_data);
        if (smp_last) begin
          st  <= S_ARM;
          cnt <= '0;
          nh  <= '0;
          for (int i = 0; i < 2; i++) begin
            q[i] <= '0;
            t[i] <= '0;
          end
        end else begin
          st  <= st_n;
          cnt <= cnt_n;
          nh  <= nh_n;
          q   <= q_n;
          t   <= t_n;
        end
      end
    end
  end
endmodule

// File: rtl/pulse_hit_extractor_chk.sv
module pulse_hit_extractor_chk #(
  parameter int QW   = 20,
  parameter int TW   = 10,
  parameter int HMIN = 20
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 smp_valid,
  input logic                 smp_last,
  input logic                 rec_ready,
  input logic                 rec_valid,
  input logic [1:0]           rec_hits,
  input logic signed [QW-1:0] rec_q0,
  input logic [TW-1:0]        rec_t0,
  input logic signed [QW-1:0] rec_q1,
  input logic [TW-1:0]        rec_t1,
  input logic                 supp_flag
);
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_ready && !(smp_valid && smp_last)) |=>
      (rec_valid && $stable(rec_hits) && $stable(rec_q0) && $stable(rec_t0)
       && $stable(rec_q1) && $stable(rec_t1)));

  a_r8_rise_after_end: assert property (@(posedge clk) disable iff (rst)
    $rose(rec_valid) |-> $past(smp_valid && smp_last));

  a_r7_supp_after_end: assert property (@(posedge clk) disable iff (rst)
    supp_flag |-> $past(smp_valid && smp_last));

  a_r7_supp_no_record: assert property (@(posedge clk) disable iff (rst)
    supp_flag |-> !$rose(rec_valid));

  a_r6_hit_count: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> (rec_hits == 2'd1 || rec_hits == 2'd2));

  a_r6_order: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_hits == 2'd2) |-> (rec_t1 > rec_t0));

  a_r8_empty_slot: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_hits == 2'd1) |-> (rec_q1 == '0 && rec_t1 == '0));

  a_r11_guard: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> (rec_t0 >= TW'(HMIN)));

  a_r10_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rec_valid && !supp_flag));
endmodule

bind pulse_hit_extractor pulse_hit_extractor_chk #(
  .QW(QW), .TW(TW), .HMIN(PED_LEN + PED_GAP)
) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_last(smp_last),
  .rec_ready(rec_ready), .rec_valid(rec_valid), .rec_hits(rec_hits),
  .rec_q0(rec_q0), .rec_t0(rec_t0), .rec_q1(rec_q1), .rec_t1(rec_t1),
  .supp_flag(supp_flag)
);

// File: tb/test_pulse_hit_extractor.sv
module test_pulse_hit_extractor;
  localparam int SW = 12;
  localparam int QW = 14;
  localparam int TW = 10;
  localparam int LW = 6;
  localparam int QHI = (1 << (QW-1)) - 1;
  localparam int QLO = -(1 << (QW-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0, smp_first = 1'b0, smp_last = 1'b0, rec_ready = 1'b1;
  logic [SW-1:0] smp_data = '0, slope_thr = '0;
  logic [LW-1:0] int_len = '0;
  logic rec_valid, supp_flag;
  logic [1:0] rec_hits;
  logic signed [QW-1:0] rec_q0, rec_q1;
  logic [TW-1:0] rec_t0, rec_t1;

  always #4 clk = ~clk;

  pulse_hit_extractor #(.SW(SW), .QW(QW), .TW(TW), .LW(LW)) i_pulse_hit_extractor (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_first(smp_first), .smp_last(smp_last), .slope_thr(slope_thr),
    .int_len(int_len), .rec_ready(rec_ready), .rec_valid(rec_valid),
    .rec_hits(rec_hits), .rec_q0(rec_q0), .rec_t0(rec_t0), .rec_q1(rec_q1),
    .rec_t1(rec_t1), .supp_flag(supp_flag)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int wav [0:255];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model
  int m_idx, m_prev, m_pacc, m_st, m_cnt, m_nh;
  int m_q [2];
  int m_t [2];
  int e_v, e_n, e_q0, e_t0, e_q1, e_t1, e_s;

  function automatic int clamp(input int v);
    if (v > QHI) return QHI;
    if (v < QLO) return QLO;
    return v;
  endfunction

  always @(posedge clk) begin
    int cur, d, ped, term, s;
    bit ld;
    if (rst) begin
      m_idx = 0; m_prev = 0; m_pacc = 0; m_st = 0; m_cnt = 0; m_nh = 0;
      m_q[0] = 0; m_q[1] = 0; m_t[0] = 0; m_t[1] = 0;
      e_v = 0; e_n = 0; e_q0 = 0; e_t0 = 0; e_q1 = 0; e_t1 = 0; e_s = 0;
    end else begin
      e_s = 0;
      ld = 0;
      if (smp_valid) begin
        s = int'(smp_data);
        cur = smp_first ? 0 : m_idx;
        d = s - m_prev;
        ped = m_pacc / 16;
        term = s - ped;
        if (cur == 0) m_pacc = s;
        else if (cur < 16) m_pacc = m_pacc + s;
        case (m_st)
          0: if (cur >= 20 && d > int'(slope_thr) && m_nh < 2) begin
               m_q[m_nh] = term;
               m_t[m_nh] = cur;
               m_nh++;
               if (int'(int_len) <= 1) m_st = 2;
               else begin m_cnt = int'(int_len) - 1; m_st = 1; end
             end
          1: begin
               m_q[m_nh-1] = clamp(m_q[m_nh-1] + term);
               m_cnt--;
               if (m_cnt == 0) m_st = 2;
             end
          default: if (d <= int'(slope_thr)) m_st = 0;
        endcase
        m_prev = s;
        m_idx = (cur + 1) % (1 << TW);
        if (smp_last) begin
          if (m_nh > 0) begin
            ld = 1;
            e_n = m_nh; e_q0 = m_q[0]; e_t0 = m_t[0]; e_q1 = m_q[1]; e_t1 = m_t[1];
          end else e_s = 1;
          m_st = 0; m_cnt = 0; m_nh = 0;
          m_q[0] = 0; m_q[1] = 0; m_t[0] = 0; m_t[1] = 0;
        end
      end
      if (ld) e_v = 1;
      else if (rec_ready) e_v = 0;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(rec_valid == e_v[0], "R8 valid", int'(rec_valid), e_v);
      chk(supp_flag == e_s[0], "R7 suppress", int'(supp_flag), e_s);
      if (e_v != 0) begin
        chk(int'(rec_hits) == e_n, "R6 hit count", int'(rec_hits), e_n);
        chk(int'(rec_q0) == e_q0, "R3 charge0", int'(rec_q0), e_q0);
        chk(int'(rec_t0) == e_t0, "R5 time0", int'(rec_t0), e_t0);
        chk(int'(rec_q1) == e_q1, "R3 charge1", int'(rec_q1), e_q1);
        chk(int'(rec_t1) == e_t1, "R5 time1", int'(rec_t1), e_t1);
      end
    end
  end

  task automatic fill(input int a, input int b, input int v);
    for (int i = a; i <= b; i++) wav[i] = v;
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = SW'(wav[i]);
      smp_first = (i == 0);
      smp_last  = (i == n - 1);
    end
    @(negedge clk);
    smp_valid = 1'b0; smp_first = 1'b0; smp_last = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_rec(input string tag, input int n, input int q0, input int t0,
                         input int q1, input int t1);
    chk(rec_valid == 1'b1, {tag, " valid"}, int'(rec_valid), 1);
    chk(int'(rec_hits) == n, {tag, " hits"}, int'(rec_hits), n);
    chk(int'(rec_q0) == q0, {tag, " q0"}, int'(rec_q0), q0);
    chk(int'(rec_t0) == t0, {tag, " t0"}, int'(rec_t0), t0);
    chk(int'(rec_q1) == q1, {tag, " q1"}, int'(rec_q1), q1);
    chk(int'(rec_t1) == t1, {tag, " t1"}, int'(rec_t1), t1);
  endtask

  task automatic exp_supp(input string tag);
    chk(supp_flag == 1'b1, {tag, " supp"}, int'(supp_flag), 1);
    chk(rec_valid == 1'b0, {tag, " no record"}, int'(rec_valid), 0);
  endtask

  initial begin
    idle(3);
    chk(rec_valid == 1'b0, "R10 reset valid", int'(rec_valid), 0);
    chk(supp_flag == 1'b0, "R10 reset supp", int'(supp_flag), 0);
    chk(rec_hits == 2'd0, "R10 reset hits", int'(rec_hits), 0);
    rst = 1'b0;
    idle(2);

    // R1 R3 R5: single step pulse
    slope_thr = 50; int_len = 4;
    fill(0, 59, 100); fill(30, 39, 300);
    send(60);
    exp_rec("R1 R3 R5 single", 1, 800, 30, 0, 0);
    idle(2);

    // R6: two hits, third ignored
    int_len = 3;
    fill(0, 59, 100); fill(25, 27, 400); fill(40, 42, 250); wav[50] = 500;
    send(60);
    exp_rec("R6 two hits", 2, 900, 25, 450, 40);
    idle(2);

    // R1 R7: slope equal to threshold does not fire
    fill(0, 39, 100); wav[30] = 150;
    send(40);
    exp_supp("R1 R7 equal slope");
    idle(1);
    chk(supp_flag == 1'b0, "R7 one-cycle pulse", int'(supp_flag), 0);
    idle(2);

    // R11: steep edges inside guard region
    fill(0, 39, 100); fill(18, 19, 1100);
    send(40);
    exp_supp("R11 guard");
    idle(2);

    // R2: baseline rounding
    int_len = 2;
    for (int i = 0; i < 16; i++) wav[i] = (i % 2 == 1) ? 107 : 100;
    fill(16, 39, 100); fill(30, 31, 200);
    send(40);
    exp_rec("R2 baseline", 1, 194, 30, 0, 0);
    idle(2);

    // R4: positive saturation
    slope_thr = 100; int_len = 63;
    fill(0, 69, 0); fill(20, 69, 4095);
    send(70);
    exp_rec("R4 positive sat", 1, QHI, 20, 0, 0);
    idle(2);

    // R4: negative saturation
    slope_thr = 0; int_len = 10;
    fill(0, 19, 4000); wav[20] = 0; fill(21, 39, 1);
    send(40);
    exp_rec("R4 negative sat", 1, QLO, 21, 0, 0);
    idle(2);

    // R3: waveform ends inside window
    slope_thr = 50; int_len = 20;
    fill(0, 34, 100); fill(30, 34, 300);
    send(35);
    exp_rec("R3 partial", 1, 1000, 30, 0, 0);
    idle(2);

    // R6: re-arm waits for slope to fall
    slope_thr = 10; int_len = 2;
    fill(0, 59, 400); fill(0, 29, 100);
    for (int k = 0; k < 15; k++) wav[30 + k] = 120 + 20 * k;
    fill(50, 51, 700);
    send(60);
    exp_rec("R6 rearm", 2, 60, 30, 1200, 50);
    idle(2);

    // R3: window of one sample
    slope_thr = 50; int_len = 1;
    fill(0, 49, 100); wav[25] = 300; wav[30] = 300;
    send(50);
    exp_rec("R3 window one", 2, 200, 25, 200, 30);
    idle(2);

    // R8 R9: stalled consumer
    rec_ready = 1'b0; int_len = 4;
    fill(0, 59, 100); fill(30, 39, 300);
    send(60);
    exp_rec("R8 stalled", 1, 800, 30, 0, 0);
    idle(6);
    exp_rec("R8 held", 1, 800, 30, 0, 0);
    int_len = 2;
    for (int i = 0; i < 16; i++) wav[i] = (i % 2 == 1) ? 107 : 100;
    fill(16, 39, 100); fill(30, 31, 200);
    send(40);
    exp_rec("R9 replaced", 1, 194, 30, 0, 0);
    rec_ready = 1'b1;
    idle(1);
    chk(rec_valid == 1'b0, "R8 taken", int'(rec_valid), 0);

    // R10: reset with record pending
    rec_ready = 1'b0;
    fill(0, 59, 100); fill(30, 39, 300);
    send(60);
    rst = 1'b1;
    idle(2);
    chk(rec_valid == 1'b0, "R10 reset clears record", int'(rec_valid), 0);
    rst = 1'b0; rec_ready = 1'b1;
    idle(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule